// File: doc/BRIEF.md
# Subsleep Power-Mode Controller

This block is the power-mode sequencer of a small microcontroller. It follows the part through five states: full-speed active, low-speed subactive, subsleep, a reset-wait phase in which the main oscillator settles, and hardware standby. Its outputs gate the CPU clock, the general peripheral clock and a separate always-on clock group that feeds the 8-bit timers and the watchdogs. It also drives the main oscillator enable.

Software moves between active and subactive with a speed-switch strobe. A sleep strobe issued in subactive enters subsleep only when three mode-select bits carry the right values. In subsleep, four classes of wake source can bring the part back to subactive, which raises a one-cycle request that starts interrupt exception handling. These classes are external IRQ lines, key inputs, wake-event lines and on-chip peripheral interrupts, and each class has its own gating. The NMI input can also wake the part. A low reset pin starts the oscillator and holds the part in reset-wait while a programmable settling count runs down. A low standby pin overrides every other input.

The reset pin, the standby pin, NMI and the external wake lines each pass through a two-flop synchroniser. A change on one of them therefore reaches the state on the third rising clock edge after it appears.

Top module: `pmc_subsleep_ctrl`

## Requirements
- R1: A `sleep_exec` pulse moves the state from subactive to subsleep only when `sel_standby`=0, `sel_lowspeed`=1 and `sel_wdtsub`=1. With any other combination of these bits, or in any other state, the pulse has no effect.
- R2: In subsleep (`state_o`=2), `cpu_clk_en`=0, `per_clk_en`=0, `keep_clk_en`=1 and `osc_en`=0.
- R3: Reset of the block selects active (`state_o`=0). The four gates are all 1 in active and in reset-wait (`state_o`=3). In subactive (`state_o`=1) they are 1 except `osc_en`=0. In hardware standby (`state_o`=4) they are all 0.
- R4: A high line `irq_in[i]` wakes the part from subsleep only if `irq_en[i]`=1 and `cpu_mask`=0.
- R5: A high line `key_in[i]` or `wue_in[i]` wakes the part only if its bit in `key_ie` or `wue_ie` is 1 and `cpu_mask`=0. The state changes on the third rising edge after the line rises.
- R6: A high line `per_irq[i]` wakes the part only if `per_ie[i]`=1 and `cpu_mask`=0. This input is not synchronised, so it acts on the next edge.
- R7: A high `nmi_in` wakes the part from subsleep whatever the value of `cpu_mask`.
- R8: A wake returns the state to subactive and drives `wake_req` high for exactly one cycle.
- R9: When `rst_n_pin` is low, the state moves to reset-wait from any state other than standby. The move takes effect on the third rising edge after the pin falls and wins over a wake that arrives at the same time. On entry the settle counter loads `settle_cycles`, then counts down by one each cycle.
- R10: If `rst_n_pin` rises in reset-wait after the counter has reached zero, the state moves to active and `reset_exc` pulses high for one cycle.
- R11: If `rst_n_pin` rises before the counter has reached zero, `settle_err` pulses for one cycle, the state stays in reset-wait and `reset_exc` stays low.
- R12: A low `stby_n_pin` forces hardware standby from any state, ahead of reset and wake. The part leaves standby only when the standby pin is high and `rst_n_pin` is low, and it then goes to reset-wait.
- R13: A `speed_toggle` pulse switches between active and subactive. It has no effect in the other states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_exec | input | 1 | One-cycle strobe: sleep instruction executed |
| speed_toggle | input | 1 | One-cycle strobe: switch between active and subactive |
| sel_standby | input | 1 | Standby-select mode bit (must be 0 for subsleep) |
| sel_lowspeed | input | 1 | Low-speed-on mode bit (must be 1 for subsleep) |
| sel_wdtsub | input | 1 | Watchdog sub-clock select bit (must be 1 for subsleep) |
| irq_in | input | 16 | External IRQ lines, asynchronous |
| irq_en | input | 16 | Per-line IRQ enable |
| key_in | input | 16 | Key-input lines, asynchronous |
| key_ie | input | 16 | Per-line key input enable |
| wue_in | input | 8 | Wake-event lines, asynchronous |
| wue_ie | input | 8 | Per-line wake-event input enable |
| nmi_in | input | 1 | Non-maskable interrupt, asynchronous |
| per_irq | input | 8 | On-chip peripheral interrupt requests |
| per_ie | input | 8 | Per-request peripheral interrupt enable |
| cpu_mask | input | 1 | CPU interrupt mask, 1 blocks all maskable sources |
| rst_n_pin | input | 1 | Reset pin, active low, asynchronous |
| stby_n_pin | input | 1 | Standby pin, active low, asynchronous |
| settle_cycles | input | 16 | Oscillator settling count in clock cycles |
| cpu_clk_en | output | 1 | CPU clock gate |
| per_clk_en | output | 1 | General peripheral clock gate |
| keep_clk_en | output | 1 | Clock gate for the timers and watchdogs |
| osc_en | output | 1 | Main oscillator enable |
| wake_req | output | 1 | One-cycle request to start interrupt exception handling |
| reset_exc | output | 1 | One-cycle reset exception strobe |
| settle_err | output | 1 | One-cycle flag: reset released before settling ended |
| state_o | output | 3 | Current state: 0 active, 1 subactive, 2 subsleep, 3 reset-wait, 4 standby |

## Verification
The bench tries each wrong bit of the sleep qualifier on its own. A design that decoded only part of the qualifier would fall asleep on one of these attempts. Each wake class is raised with its enable clear, then with the enable set while the mask is up, and then with the mask cleared. A design that missed one gate would wake one step too early, and the bench checks that NMI wakes the part even with the mask up. The reset pin is released once after settling and once before it. A design that started from a stale count would raise the reset exception early or never. Last, the bench drives standby together with reset and NMI, and it leaves standby with reset high. A design with the wrong priority, or one that left standby without a reset, would show the wrong state code.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        PM_ACTIVE   = 3'd0,
        PM_SUBACT   = 3'd1,
        PM_SUBSLEEP = 3'd2,
        PM_RSTWAIT  = 3'd3,
        PM_HWSTBY   = 3'd4
    } pm_state_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic keep;
        logic osc;
    } clk_plan_t;

    typedef struct packed {
        logic wake;
        logic rexc;
        logic err;
    } pm_pulse_t;

    function automatic clk_plan_t plan_for(pm_state_e s);
        clk_plan_t p;
        unique case (s)
            PM_ACTIVE:   p = '{cpu: 1'b1, per: 1'b1, keep: 1'b1, osc: 1'b1};
            PM_SUBACT:   p = '{cpu: 1'b1, per: 1'b1, keep: 1'b1, osc: 1'b0};
            PM_SUBSLEEP: p = '{cpu: 1'b0, per: 1'b0, keep: 1'b1, osc: 1'b0};
            PM_RSTWAIT:  p = '{cpu: 1'b1, per: 1'b1, keep: 1'b1, osc: 1'b1};
            default:     p = '{cpu: 1'b0, per: 1'b0, keep: 1'b0, osc: 1'b0};
        endcase
        return p;
    endfunction

    function automatic logic sleep_qualified(logic stby_sel, logic low_on, logic wdt_sub);
        return !stby_sel && low_on && wdt_sub;
    endfunction

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int             W    = 1,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= INIT;
            q    <= INIT;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pmc_wake_eval.sv
module pmc_wake_eval #(
    parameter int N_IRQ = 16,
    parameter int N_KEY = 16,
    parameter int N_WUE = 8,
    parameter int N_PER = 8
) (
    input  logic [N_IRQ-1:0] irq_s,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_KEY-1:0] key_s,
    input  logic [N_KEY-1:0] key_ie,
    input  logic [N_WUE-1:0] wue_s,
    input  logic [N_WUE-1:0] wue_ie,
    input  logic [N_PER-1:0] per_irq,
    input  logic [N_PER-1:0] per_ie,
    input  logic             nmi_s,
    input  logic             cpu_mask,
    output logic             wake
);
    localparam int N_CLASS = 4;

    logic [N_CLASS-1:0] class_hit;

    genvar gi;
    generate
        for (gi = 0; gi < N_CLASS; gi++) begin : g_class
            if (gi == 0) begin : g_irq
                assign class_hit[gi] = |(irq_s & irq_en);
            end else if (gi == 1) begin : g_key
                assign class_hit[gi] = |(key_s & key_ie);
            end else if (gi == 2) begin : g_wue
                assign class_hit[gi] = |(wue_s & wue_ie);
            end else begin : g_per
                assign class_hit[gi] = |(per_irq & per_ie);
            end
        end
    endgenerate

    assign wake = nmi_s || (!cpu_mask && |class_hit);
endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          settled
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign settled = (cnt == '0);
endmodule

// File: rtl/pmc_subsleep_ctrl.sv
module pmc_subsleep_ctrl
    import pmc_pkg::*;
#(
    parameter int N_IRQ = 16,
    parameter int N_KEY = 16,
    parameter int N_WUE = 8,
    parameter int N_PER = 8,
    parameter int CW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_exec,
    input  logic             speed_toggle,
    input  logic             sel_standby,
    input  logic             sel_lowspeed,
    input  logic             sel_wdtsub,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_KEY-1:0] key_in,
    input  logic [N_KEY-1:0] key_ie,
    input  logic [N_WUE-1:0] wue_in,
    input  logic [N_WUE-1:0] wue_ie,
    input  logic             nmi_in,
    input  logic [N_PER-1:0] per_irq,
    input  logic [N_PER-1:0] per_ie,
    input  logic             cpu_mask,
    input  logic             rst_n_pin,
    input  logic             stby_n_pin,
    input  logic [CW-1:0]    settle_cycles,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             keep_clk_en,
    output logic             osc_en,
    output logic             wake_req,
    output logic             reset_exc,
    output logic             settle_err,
    output logic [2:0]       state_o
);
    localparam int NA = N_IRQ + N_KEY + N_WUE + 1;

    logic [NA-1:0]    evt_s;
    logic [N_IRQ-1:0] irq_s;
    logic [N_KEY-1:0] key_s;
    logic [N_WUE-1:0] wue_s;
    logic             nmi_s;
    logic             stby_n_s;
    logic             rst_n_s;
    logic             rst_n_d;
    logic             rst_rise;
    logic             wake_any;
    logic             settled;
    logic             go_wait;
    pm_state_e        st;
    pm_state_e        nxt;
    pm_pulse_t        pls;
    clk_plan_t        gates;

    pmc_sync #(.W(NA), .INIT('0)) u_sync_evt (
        .clk (clk),
        .rst (rst),
        .d   ({nmi_in, wue_in, key_in, irq_in}),
        .q   (evt_s)
    );

    pmc_sync #(.W(2), .INIT(2'b11)) u_sync_pin (
        .clk (clk),
        .rst (rst),
        .d   ({stby_n_pin, rst_n_pin}),
        .q   ({stby_n_s, rst_n_s})
    );

    assign irq_s = evt_s[N_IRQ-1:0];
    assign key_s = evt_s[N_IRQ +: N_KEY];
    assign wue_s = evt_s[N_IRQ+N_KEY +: N_WUE];
    assign nmi_s = evt_s[NA-1];

    pmc_wake_eval #(
        .N_IRQ (N_IRQ),
        .N_KEY (N_KEY),
        .N_WUE (N_WUE),
        .N_PER (N_PER)
    ) u_wake (
        .irq_s    (irq_s),
        .irq_en   (irq_en),
        .key_s    (key_s),
        .key_ie   (key_ie),
        .wue_s    (wue_s),
        .wue_ie   (wue_ie),
        .per_irq  (per_irq),
        .per_ie   (per_ie),
        .nmi_s    (nmi_s),
        .cpu_mask (cpu_mask),
        .wake     (wake_any)
    );

    pmc_settle_timer #(.CW(CW)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .load     (go_wait),
        .load_val (settle_cycles),
        .run      (st == PM_RSTWAIT),
        .settled  (settled)
    );

    assign rst_rise = rst_n_s && !rst_n_d;

    // Priority: standby pin, then reset pin, then wake and software strobes.
    always_comb begin
        nxt     = st;
        go_wait = 1'b0;
        pls     = '0;
        if (!stby_n_s) begin
            nxt = PM_HWSTBY;
        end else begin
            unique case (st)
                PM_HWSTBY: begin
                    if (!rst_n_s) begin
                        nxt     = PM_RSTWAIT;
                        go_wait = 1'b1;
                    end
                end
                PM_RSTWAIT: begin
                    if (rst_rise) begin
                        if (settled) begin
                            nxt      = PM_ACTIVE;
                            pls.rexc = 1'b1;
                        end else begin
                            pls.err = 1'b1;
                        end
                    end
                end
                default: begin
                    if (!rst_n_s) begin
                        nxt     = PM_RSTWAIT;
                        go_wait = 1'b1;
                    end else begin
                        unique case (st)
                            PM_ACTIVE: begin
                                if (speed_toggle) nxt = PM_SUBACT;
                            end
                            PM_SUBACT: begin
                                if (sleep_exec && sleep_qualified(sel_standby, sel_lowspeed, sel_wdtsub))
                                    nxt = PM_SUBSLEEP;
                                else if (speed_toggle)
                                    nxt = PM_ACTIVE;
                            end
                            PM_SUBSLEEP: begin
                                if (wake_any) begin
                                    nxt      = PM_SUBACT;
                                    pls.wake = 1'b1;
                                end
                            end
                            default: nxt = st;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= PM_ACTIVE;
            rst_n_d    <= 1'b1;
            wake_req   <= 1'b0;
            reset_exc  <= 1'b0;
            settle_err <= 1'b0;
        end else begin
            st         <= nxt;
            rst_n_d    <= rst_n_s;
            wake_req   <= pls.wake;
            reset_exc  <= pls.rexc;
            settle_err <= pls.err;
        end
    end

    assign gates       = plan_for(st);
    assign cpu_clk_en  = gates.cpu;
    assign per_clk_en  = gates.per;
    assign keep_clk_en = gates.keep;
    assign osc_en      = gates.osc;
    assign state_o     = st;
endmodule

// File: rtl/pmc_subsleep_chk.sv
module pmc_subsleep_chk
    import pmc_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input pm_state_e st,
    input logic      stby_n_s,
    input logic      rst_n_s,
    input logic      sleep_exec,
    input logic      sel_standby,
    input logic      sel_lowspeed,
    input logic      sel_wdtsub,
    input logic      cpu_clk_en,
    input logic      per_clk_en,
    input logic      keep_clk_en,
    input logic      osc_en,
    input logic      wake_req,
    input logic      reset_exc,
    input logic      settle_err
);
    p_sleep_qual_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(st == PM_SUBSLEEP) |->
            $past(sleep_exec && !sel_standby && sel_lowspeed && sel_wdtsub && st == PM_SUBACT));

    p_sleep_gates_r2: assert property (@(posedge clk) disable iff (rst)
        (st == PM_SUBSLEEP) |-> (!cpu_clk_en && !per_clk_en && keep_clk_en && !osc_en));

    p_wait_gates_r3: assert property (@(posedge clk) disable iff (rst)
        (st == PM_RSTWAIT) |-> (cpu_clk_en && per_clk_en && keep_clk_en && osc_en));

    p_wake_ret_r8: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (st == PM_SUBACT && $past(st) == PM_SUBSLEEP));

    p_pin_reset_r9: assert property (@(posedge clk) disable iff (rst)
        (stby_n_s && !rst_n_s && st != PM_HWSTBY) |=> (st == PM_RSTWAIT));

    p_rexc_path_r10: assert property (@(posedge clk) disable iff (rst)
        reset_exc |-> (st == PM_ACTIVE && $past(st) == PM_RSTWAIT));

    p_early_stay_r11: assert property (@(posedge clk) disable iff (rst)
        settle_err |-> (st == PM_RSTWAIT && $past(st) == PM_RSTWAIT && !reset_exc));

    p_stby_first_r12: assert property (@(posedge clk) disable iff (rst)
        !stby_n_s |=> (st == PM_HWSTBY));
endmodule

bind pmc_subsleep_ctrl pmc_subsleep_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .st           (st),
    .stby_n_s     (stby_n_s),
    .rst_n_s      (rst_n_s),
    .sleep_exec   (sleep_exec),
    .sel_standby  (sel_standby),
    .sel_lowspeed (sel_lowspeed),
    .sel_wdtsub   (sel_wdtsub),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .keep_clk_en  (keep_clk_en),
    .osc_en       (osc_en),
    .wake_req     (wake_req),
    .reset_exc    (reset_exc),
    .settle_err   (settle_err)
);

// File: tb/pmc_subsleep_ctrl_test.sv
module pmc_subsleep_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_exec = 1'b0, speed_toggle = 1'b0;
    logic        sel_standby = 1'b0, sel_lowspeed = 1'b0, sel_wdtsub = 1'b0;
    logic [15:0] irq_in = '0, irq_en = '0, key_in = '0, key_ie = '0;
    logic [7:0]  wue_in = '0, wue_ie = '0, per_irq = '0, per_ie = '0;
    logic        nmi_in = 1'b0, cpu_mask = 1'b0;
    logic        rst_n_pin = 1'b1, stby_n_pin = 1'b1;
    logic [15:0] settle_cycles = 16'd8;
    logic        cpu_clk_en, per_clk_en, keep_clk_en, osc_en;
    logic        wake_req, reset_exc, settle_err;
    logic [2:0]  state_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        int    st;
        bit    wk;
        bit    rx;
        bit    er;
        string req;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    pmc_subsleep_ctrl uut (
        .clk (clk), .rst (rst), .sleep_exec (sleep_exec), .speed_toggle (speed_toggle),
        .sel_standby (sel_standby), .sel_lowspeed (sel_lowspeed), .sel_wdtsub (sel_wdtsub),
        .irq_in (irq_in), .irq_en (irq_en), .key_in (key_in), .key_ie (key_ie),
        .wue_in (wue_in), .wue_ie (wue_ie), .nmi_in (nmi_in), .per_irq (per_irq),
        .per_ie (per_ie), .cpu_mask (cpu_mask), .rst_n_pin (rst_n_pin),
        .stby_n_pin (stby_n_pin), .settle_cycles (settle_cycles),
        .cpu_clk_en (cpu_clk_en), .per_clk_en (per_clk_en), .keep_clk_en (keep_clk_en),
        .osc_en (osc_en), .wake_req (wake_req), .reset_exc (reset_exc),
        .settle_err (settle_err), .state_o (state_o)
    );

    // Gate values per state code, taken from R2 and R3.
    function automatic logic [3:0] gates_for(int s);
        case (s)
            0, 3:    return 4'b1111;
            1:       return 4'b1110;
            2:       return 4'b0010;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(int st, bit wk, bit rx, bit er, string req);
        exp_t e;
        e.st = st; e.wk = wk; e.rx = rx; e.er = er; e.req = req;
        sb.push_back(e);
        #1;
    endtask

    // Monitor: pops each expected item and compares it with the outputs.
    initial begin
        forever begin
            exp_t e;
            logic [6:0] act, exp_v;
            wait (sb.size() > 0);
            e = sb.pop_front();
            act   = {cpu_clk_en, per_clk_en, keep_clk_en, osc_en, wake_req, reset_exc, settle_err};
            exp_v = {gates_for(e.st), e.wk, e.rx, e.er};
            checks++;
            if (state_o != 3'(e.st) || act != exp_v) begin
                failures++;
                $display("FAIL %s: state=%0d gates/pulses=%b expected state=%0d gates/pulses=%b",
                         e.req, state_o, act, e.st, exp_v);
            end
        end
    end

    task automatic go_sleep(string req);
        sel_standby = 1'b0; sel_lowspeed = 1'b1; sel_wdtsub = 1'b1;
        sleep_exec = 1'b1;
        tick(1);
        sleep_exec = 1'b0;
        expect_out(2, 0, 0, 0, req);
    endtask

    initial begin
        @(negedge clk);
        tick(2);
        expect_out(0, 0, 0, 0, "R3 reset state");
        rst = 1'b0;
        tick(1);

        // R13: speed switch into subactive
        speed_toggle = 1'b1; tick(1); speed_toggle = 1'b0;
        expect_out(1, 0, 0, 0, "R13 toggle to subactive");

        // R1: each wrong qualifier bit blocks entry
        sel_standby = 1'b0; sel_lowspeed = 1'b0; sel_wdtsub = 1'b1;
        sleep_exec = 1'b1; tick(1); sleep_exec = 1'b0;
        expect_out(1, 0, 0, 0, "R1 lowspeed=0");
        sel_standby = 1'b1; sel_lowspeed = 1'b1;
        sleep_exec = 1'b1; tick(1); sleep_exec = 1'b0;
        expect_out(1, 0, 0, 0, "R1 standby_sel=1");
        sel_standby = 1'b0; sel_wdtsub = 1'b0;
        sleep_exec = 1'b1; tick(1); sleep_exec = 1'b0;
        expect_out(1, 0, 0, 0, "R1 wdtsub=0");
        go_sleep("R1 R2 qualified entry");

        // R4: IRQ gating
        irq_in[5] = 1'b1; tick(4);
        expect_out(2, 0, 0, 0, "R4 irq enable clear");
        irq_en[5] = 1'b1; cpu_mask = 1'b1; tick(1);
        expect_out(2, 0, 0, 0, "R4 irq masked");
        cpu_mask = 1'b0; tick(1);
        expect_out(1, 1, 0, 0, "R4 R8 irq wake");
        tick(1);
        expect_out(1, 0, 0, 0, "R8 wake pulse one cycle");
        irq_in = '0; irq_en = '0; tick(3);

        // R5: key input gating
        go_sleep("R1 re-entry");
        key_in[9] = 1'b1; tick(4);
        expect_out(2, 0, 0, 0, "R5 key input disabled");
        key_ie[9] = 1'b1; cpu_mask = 1'b1; tick(1);
        expect_out(2, 0, 0, 0, "R5 key masked");
        cpu_mask = 1'b0; tick(1);
        expect_out(1, 1, 0, 0, "R5 key wake");
        key_in = '0; key_ie = '0; tick(3);

        // R5: wake-event line latency
        go_sleep("R1 re-entry");
        wue_ie[2] = 1'b1; wue_in[2] = 1'b1; tick(2);
        expect_out(2, 0, 0, 0, "R5 wue not yet through sync");
        tick(1);
        expect_out(1, 1, 0, 0, "R5 wue wake third edge");
        wue_in = '0; wue_ie = '0; tick(3);

        // R6: peripheral gating
        go_sleep("R1 re-entry");
        per_irq[4] = 1'b1; tick(2);
        expect_out(2, 0, 0, 0, "R6 per enable clear");
        per_ie[4] = 1'b1; cpu_mask = 1'b1; tick(1);
        expect_out(2, 0, 0, 0, "R6 per masked");
        cpu_mask = 1'b0; tick(1);
        expect_out(1, 1, 0, 0, "R6 per wake");
        per_irq = '0; per_ie = '0; tick(1);

        // R7: NMI ignores mask
        go_sleep("R1 re-entry");
        cpu_mask = 1'b1; nmi_in = 1'b1; tick(3);
        expect_out(1, 1, 0, 0, "R7 nmi wake under mask");
        nmi_in = 1'b0; cpu_mask = 1'b0; tick(3);

        // R9: reset beats simultaneous wake, then R10 normal release
        go_sleep("R1 re-entry");
        settle_cycles = 16'd10;
        rst_n_pin = 1'b0; nmi_in = 1'b1; tick(2);
        expect_out(2, 0, 0, 0, "R9 reset not yet through sync");
        tick(1);
        expect_out(3, 0, 0, 0, "R9 reset-wait wins over wake");
        nmi_in = 1'b0;
        tick(15);
        expect_out(3, 0, 0, 0, "R9 held in reset-wait");
        rst_n_pin = 1'b1; tick(3);
        expect_out(0, 0, 1, 0, "R10 reset exception after settling");
        tick(1);
        expect_out(0, 0, 0, 0, "R10 pulse one cycle");

        // R11: early release
        settle_cycles = 16'd200;
        rst_n_pin = 1'b0; tick(3);
        expect_out(3, 0, 0, 0, "R9 reset from active");
        tick(3);
        rst_n_pin = 1'b1; tick(3);
        expect_out(3, 0, 0, 1, "R11 early release flagged");
        tick(1);
        expect_out(3, 0, 0, 0, "R11 no exception after early release");
        rst_n_pin = 1'b0; tick(250);
        rst_n_pin = 1'b1; tick(3);
        expect_out(0, 0, 1, 0, "R10 R11 release after settling");

        // R1: sleep strobe in active has no effect
        sleep_exec = 1'b1; tick(1); sleep_exec = 1'b0;
        expect_out(0, 0, 0, 0, "R1 sleep ignored in active");

        // R12: standby priority
        speed_toggle = 1'b1; tick(1); speed_toggle = 1'b0;
        expect_out(1, 0, 0, 0, "R13 toggle to subactive");
        go_sleep("R1 re-entry");
        stby_n_pin = 1'b0; tick(3);
        expect_out(4, 0, 0, 0, "R12 standby from subsleep");
        rst_n_pin = 1'b0; nmi_in = 1'b1; tick(4);
        expect_out(4, 0, 0, 0, "R12 standby over reset and nmi");
        nmi_in = 1'b0;
        settle_cycles = 16'd5;
        stby_n_pin = 1'b1; tick(3);
        expect_out(3, 0, 0, 0, "R12 leave standby into reset-wait");
        tick(8);
        rst_n_pin = 1'b1; tick(3);
        expect_out(0, 0, 1, 0, "R10 R12 exception after standby");
        stby_n_pin = 1'b0; tick(3);
        expect_out(4, 0, 0, 0, "R12 standby from active");
        stby_n_pin = 1'b1; tick(4);
        expect_out(4, 0, 0, 0, "R12 stays in standby with reset high");
        speed_toggle = 1'b1; tick(1); speed_toggle = 1'b0;
        expect_out(4, 0, 0, 0, "R13 toggle ignored in standby");
        rst_n_pin = 1'b0; tick(3);
        expect_out(3, 0, 0, 0, "R12 reset releases standby");
        tick(8);
        rst_n_pin = 1'b1; tick(3);
        expect_out(0, 0, 1, 0, "R10 exception after standby exit");

        wait (sb.size() == 0);
        #2;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule